// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the column addresses a low-power DDR device walks through during a read or write burst. A single start strobe captures the starting column, the burst length (4 or 8 beats), the ordering rule (sequential or interleaved) and the wrap setting. From the next clock the block produces one column address per clock. Each address carries a valid flag, and the final beat also carries a last flag.

In wrap mode the addresses stay inside the aligned block whose size equals the burst length, and the column bits above that block are copied through. In no-wrap mode the address counts up across the full column width. Interleaved order combines the in-block offset of the start with the beat index by XOR. Sequential order adds the beat index to that offset, modulo the burst length.

Two request types are refused: an odd start column, and an 8-beat burst without wrap. For either one the block raises a one-cycle illegal pulse and produces no beats. A strobe that arrives while a burst is running is dropped.

Top module: `burst_col_seq`

## Requirements
- R1: After a synchronous active-low reset, beat_valid, beat_last and illegal are 0 and col_addr is 0.
- R2: With len8=0 and nowrap=0, a 4-beat burst keeps bits above bit 1 of the start column. Its low two bits run offset, offset+1, … modulo 4, which gives 0,1,2,3 from offset 0 and 2,3,0,1 from offset 2. The result is the same for interleave=0 and interleave=1.
- R3: With len8=0 and nowrap=1, the four beats are y, y+1, y+2, y+3 over the full column width, with a carry out of the 4-aligned block. For the top column the sum wraps modulo 2^COL_W.
- R4: With len8=1, interleave=0 and nowrap=0, bits above bit 2 of the start are kept. The low three bits run offset+i modulo 8 for beat i = 0..7.
- R5: With len8=1, interleave=1 and nowrap=0, bits above bit 2 of the start are kept. The low three bits are offset XOR i for beat i = 0..7. For example, start 2 gives 2,3,0,1,6,7,4,5.
- R6: A start with len8=1 and nowrap=1, in either order, raises illegal for exactly the one cycle after the strobe and produces no beat.
- R7: A start whose column bit 0 is 1 raises illegal for exactly one cycle and produces no beat.
- R8: An accepted start produces beat 0 in the cycle after the strobe. It then produces one beat per clock with beat_valid held high for 4 or 8 cycles. beat_last is high only on the final beat, and beat_valid is low in the cycle after it.
- R9: A start strobe seen while a burst is active, including during its last beat, is ignored. The running burst finishes with its original addresses, and no further burst follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Burst request strobe, sampled only when idle |
| start_col | input | COL_W | Starting column address |
| len8 | input | 1 | 0 = 4 beats, 1 = 8 beats |
| interleave | input | 1 | 0 = sequential order, 1 = interleaved order |
| nowrap | input | 1 | 0 = wrap in aligned block, 1 = linear increment |
| col_addr | output | COL_W | Column address of the current beat (0 when idle) |
| beat_valid | output | 1 | A beat is being presented |
| beat_last | output | 1 | Current beat is the final one |
| illegal | output | 1 | One-cycle pulse for a refused request |

## Verification
The 8-beat wrap cases start at offsets 0, 2, 4 and 6 under both orders. Sequential and interleaved results match at offsets 0 and 4 and differ at 2 and 6, so a swapped or merged order rule shows up as a wrong address. The 4-beat cases use starts with nonzero upper bits and starts near a block boundary, including the top column. These separate true wrapping from linear carry and catch lost upper bits. Refused requests, and strobes injected in the middle of a burst and during its last beat, show whether the state stays unchanged when it must.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
// Shared types for the burst column sequencer.
// Assumes bursts never exceed 8 beats, so a 3-bit beat index suffices.
package bcs_pkg;
    localparam int IDX_W = 3;

    typedef enum logic { ORD_SEQ = 1'b0, ORD_INT = 1'b1 } order_e;
    typedef enum logic { EDGE_WRAP = 1'b0, EDGE_LINEAR = 1'b1 } edge_e;
endpackage

// File: rtl/bcs_legal.sv
`timescale 1ns/1ps
// Request screen: flags combinations the sequencer refuses.
// Assumes a purely combinational check of the raw request fields.
module bcs_legal #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] req_col,
    input  logic             req_len8,
    input  logic             req_nowrap,
    output logic             refuse
);
    // Odd start column or 8-beat linear burst is refused.
    always_comb begin
        refuse = req_col[0] | (req_len8 & req_nowrap);
    end
endmodule

// File: rtl/bcs_ctrl.sv
`timescale 1ns/1ps
// Burst controller: captures an accepted request, counts beats and
// raises the refusal pulse. Assumes start is only honoured when idle.
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             refuse,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_len8,
    input  logic             req_order,
    input  logic             req_edge,
    output logic             running,
    output logic [IDX_W-1:0] beat_idx,
    output logic             final_beat,
    output logic [COL_W-1:0] base_q,
    output logic             len8_q,
    output order_e           order_q,
    output edge_e            edge_q,
    output logic             refuse_pulse
);
    // Final beat index depends on the captured burst length.
    always_comb begin
        final_beat = (beat_idx == (len8_q ? IDX_W'(7) : IDX_W'(3)));
    end

    // Accept or refuse while idle; step the beat index while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running      <= 1'b0;
            beat_idx     <= '0;
            base_q       <= '0;
            len8_q       <= 1'b0;
            order_q      <= ORD_SEQ;
            edge_q       <= EDGE_WRAP;
            refuse_pulse <= 1'b0;
        end else begin
            refuse_pulse <= 1'b0;
            if (!running) begin
                if (start) begin
                    if (refuse) begin
                        refuse_pulse <= 1'b1;
                    end else begin
                        running  <= 1'b1;
                        beat_idx <= '0;
                        base_q   <= req_col;
                        len8_q   <= req_len8;
                        order_q  <= order_e'(req_order);
                        edge_q   <= edge_e'(req_edge);
                    end
                end
            end else if (final_beat) begin
                running <= 1'b0;
            end else begin
                beat_idx <= beat_idx + 1'b1;
            end
        end
    end

    // R9
    // busy_hold_chk: a strobe during a burst leaves the captured start alone
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running && start |=> $stable(base_q));

    // R6 R7
    // refuse_quiet_chk: a refusal never starts a burst
    refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refuse_pulse |-> !running);
endmodule

// File: rtl/bcs_addr_gen.sv
`timescale 1ns/1ps
// Address arithmetic: forms the column of beat i from the captured start.
// Assumes COL_W >= 3 and that linear mode is only used with 4 beats.
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic             len8,
    input  order_e           order,
    input  edge_e            edge_mode,
    input  logic [IDX_W-1:0] idx,
    output logic [COL_W-1:0] addr
);
    localparam int UP_W = COL_W - IDX_W;

    logic [IDX_W-1:0] off;
    logic [IDX_W-1:0] seq_off;
    logic [IDX_W-1:0] int_off;
    logic [IDX_W-1:0] keep_mask;
    logic [IDX_W-1:0] wrap_off;

    // In-block offset for both orders, masked to the burst block size.
    always_comb begin
        off       = base[IDX_W-1:0];
        seq_off   = off + idx;
        int_off   = off ^ idx;
        keep_mask = len8 ? 3'b111 : 3'b011;
        wrap_off  = ((order == ORD_INT ? int_off : seq_off) & keep_mask)
                  | (off & ~keep_mask);
    end

    // Pick linear increment or in-block wrap.
    always_comb begin
        if (edge_mode == EDGE_LINEAR)
            addr = base + {{UP_W{1'b0}}, idx};
        else
            addr = {base[COL_W-1:IDX_W], wrap_off};
    end
endmodule

// File: rtl/burst_col_seq.sv
`timescale 1ns/1ps
// Burst column sequencer top: screens a request, runs the controller and
// presents one column address per clock. Assumes COL_W >= 3.
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             len8,
    input  logic             interleave,
    input  logic             nowrap,
    output logic [COL_W-1:0] col_addr,
    output logic             beat_valid,
    output logic             beat_last,
    output logic             illegal
);
    logic             refuse;
    logic             running;
    logic [IDX_W-1:0] beat_idx;
    logic             final_beat;
    logic [COL_W-1:0] base_q;
    logic             len8_q;
    order_e           order_q;
    edge_e            edge_q;
    logic [COL_W-1:0] gen_addr;

    bcs_legal #(.COL_W(COL_W)) u_legal (
        .req_col   (start_col),
        .req_len8  (len8),
        .req_nowrap(nowrap),
        .refuse    (refuse)
    );

    bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .refuse      (refuse),
        .req_col     (start_col),
        .req_len8    (len8),
        .req_order   (interleave),
        .req_edge    (nowrap),
        .running     (running),
        .beat_idx    (beat_idx),
        .final_beat  (final_beat),
        .base_q      (base_q),
        .len8_q      (len8_q),
        .order_q     (order_q),
        .edge_q      (edge_q),
        .refuse_pulse(illegal)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_addr (
        .base     (base_q),
        .len8     (len8_q),
        .order    (order_q),
        .edge_mode(edge_q),
        .idx      (beat_idx),
        .addr     (gen_addr)
    );

    // Drive the beat outputs, holding the address at zero when idle.
    always_comb begin
        beat_valid = running;
        beat_last  = running & final_beat;
        col_addr   = running ? gen_addr : '0;
    end

    // R8
    // last_has_valid_chk: the last flag only appears on a presented beat
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

    // R8
    // burst_continues_chk: a non-final beat is always followed by another
    burst_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_last |=> beat_valid);

    // R3
    // linear_step_chk: linear bursts advance by exactly one column per beat
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_last && edge_q == EDGE_LINEAR
        |=> col_addr == $past(col_addr) + 1'b1);

    // R2 R4 R5
    // wrap_upper_chk: wrapped beats keep the column bits above the block
    wrap_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && edge_q == EDGE_WRAP
        |-> col_addr[COL_W-1:IDX_W] == base_q[COL_W-1:IDX_W]);
endmodule

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own beats.
module sim_burst_col_seq;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic             len8 = 1'b0;
    logic             interleave = 1'b0;
    logic             nowrap = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             beat_valid;
    logic             beat_last;
    logic             illegal;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .len8(len8), .interleave(interleave), .nowrap(nowrap),
        .col_addr(col_addr), .beat_valid(beat_valid),
        .beat_last(beat_last), .illegal(illegal)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected column of beat i, derived from the requirement text.
    function automatic int model(input int y, input bit b8, input bit il,
                                 input bit lin, input int i);
        int n = b8 ? 8 : 4;
        int blk = y - (y % n);
        int off = y % n;
        if (lin) return (y + i) % (1 << COL_W);
        if (il) return blk + (off ^ i);
        return blk + ((off + i) % n);
    endfunction

    task automatic run_burst(input string req, input int y, input bit b8,
                             input bit il, input bit lin);
        int n = b8 ? 8 : 4;
        start = 1'b1; start_col = COL_W'(y); len8 = b8;
        interleave = il; nowrap = lin;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            check({req, " valid"}, int'(beat_valid), 1);
            check({req, " addr"}, int'(col_addr), model(y, b8, il, lin, i));
            check({req, " last"}, int'(beat_last), (i == n - 1) ? 1 : 0);
            @(negedge clk);
        end
        check({req, " R8 end"}, int'(beat_valid), 0);
    endtask

    task automatic run_refused(input string req, input int y, input bit b8,
                               input bit il, input bit lin);
        start = 1'b1; start_col = COL_W'(y); len8 = b8;
        interleave = il; nowrap = lin;
        @(negedge clk);
        start = 1'b0;
        check({req, " illegal"}, int'(illegal), 1);
        check({req, " no beat"}, int'(beat_valid), 0);
        @(negedge clk);
        check({req, " illegal drop"}, int'(illegal), 0);
        check({req, " still idle"}, int'(beat_valid), 0);
    endtask

    task automatic test_reset();
        check("R1 valid", int'(beat_valid), 0);
        check("R1 last", int'(beat_last), 0);
        check("R1 illegal", int'(illegal), 0);
        check("R1 addr", int'(col_addr), 0);
    endtask

    task automatic test_bl4_wrap();
        run_burst("R2 s0 seq", 0, 0, 0, 0);
        run_burst("R2 s2 seq", 2, 0, 0, 0);
        run_burst("R2 s2 int", 2, 0, 1, 0);
        run_burst("R2 upper", 10'h1A6, 0, 1, 0);
        run_burst("R2 upper seq", 10'h1A6, 0, 0, 0);
    endtask

    task automatic test_bl4_linear();
        run_burst("R3 cross", 6, 0, 0, 1);
        run_burst("R3 top", 10'h3FE, 0, 1, 1);
    endtask

    task automatic test_bl8();
        for (int s = 0; s < 8; s += 2) begin
            run_burst("R4 seq", 10'h150 + s, 1, 0, 0);
            run_burst("R5 int", 10'h2A8 + s, 1, 1, 0);
        end
    endtask

    task automatic test_refused();
        run_refused("R6 seq", 4, 1, 0, 1);
        run_refused("R6 int", 0, 1, 1, 1);
        run_refused("R7 odd", 5, 0, 0, 0);
        run_refused("R7 odd bl8", 3, 1, 1, 0);
    endtask

    // Strobes mid-burst and on the last beat must leave the burst intact.
    task automatic test_busy_ignore();
        start = 1'b1; start_col = 10'd4; len8 = 1'b1;
        interleave = 1'b0; nowrap = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            start = (i == 2 || i == 3 || i == 7);
            start_col = 10'h3F2; interleave = 1'b1; len8 = 1'b0;
            check("R9 addr", int'(col_addr), model(4, 1, 0, 0, i));
            check("R9 valid", int'(beat_valid), 1);
            @(negedge clk);
        end
        start = 1'b0;
        check("R9 no new burst", int'(beat_valid), 0);
        check("R9 no illegal", int'(illegal), 0);
        @(negedge clk);
        check("R9 still idle", int'(beat_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_bl4_wrap();
        test_bl4_linear();
        test_bl8();
        test_refused();
        test_busy_ignore();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule